// File: doc/BRIEF.md
# Clock and Low-Power Mode Controller

This block decides which reference tick stream clocks the processor core, divides that stream down, and runs the three power states: normal, wait and stop. Each oscillator appears as a one-cycle tick pulse on a single fast reference clock: main, sub-clock and ring oscillator. The outputs are clock-enable pulses, not gated clocks. A configuration write loads the divider code, the source select, the peripheral-gating bit, the settle length and a stop strobe. A wait strobe parks the core. A stop write turns every oscillator off. Only an interrupt request leaves either low-power state, apart from reset.

Divider and source changes are held pending and take effect together at the next divided-clock boundary, so the core never sees a shortened period. When the block leaves stop mode, the core and peripheral enables stay low for a programmed number of selected-source ticks. This models oscillator settling. The divider then restarts from zero.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset the mode is normal, all oscillators are enabled, the source is main and the divide is by 8: `cpu_ce` pulses on every eighth main tick.
- R2: With the main source, divider code 0, 1, 2, 3 and 4 gives a period of 1, 2, 4, 8 and 16 main ticks. Codes 5 to 7 behave as code 4.
- R3: Source code 0 selects main (divided), 1 selects the sub-clock and 2 selects the ring oscillator. Sub-clock and ring are undivided, so they have a period of 1 tick. Code 3 behaves as code 0. Ticks of unselected sources never produce `cpu_ce`.
- R4: A `wait_req` in normal mode enters wait on the next cycle. In wait, `cpu_ce` stays 0 and `per_ce` keeps pulsing at the divided rate, unless the peripheral-gate bit (`cfg_pgate`) is 1. The gate bit has no effect in normal mode.
- R5: `sub_ce` follows `sub_tick` in both normal and wait modes, whatever the gate bit says, and it is 0 in stop.
- R6: A configuration write with `cfg_stop`=1 in normal mode enters stop on the next cycle, even if `wait_req` is asserted in the same cycle. In stop, `osc_en` is 000 and `cpu_ce`, `per_ce` and `sub_ce` are 0.
- R7: Wait and stop are left only by `irq`, which returns the block to normal on the next cycle. `wait_req` and ticks are ignored in stop, and `irq` has no effect in normal mode.
- R8: After leaving stop, `cpu_ce` and `per_ce` stay 0 for `cfg_settle` ticks of the selected source. The divider then restarts from zero, so with divide-by-2 and a settle length of 3 the first `cpu_ce` comes on the fifth tick.
- R9: A new divider code or source takes effect only at the next divided-clock boundary, which is a `cpu_ce` pulse of the old setting.
- R10: The `mode` output encodes normal as 0, wait as 1 and stop as 2. The value 3 never appears.
- R11: In `osc_en`, bit 0 enables the main oscillator, bit 1 the sub-clock and bit 2 the ring oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main oscillator tick pulse |
| sub_tick | input | 1 | Sub-clock tick pulse |
| ring_tick | input | 1 | Ring oscillator tick pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 3 | Divider code for the main source |
| cfg_src | input | 2 | Clock source code |
| cfg_pgate | input | 1 | Gate peripherals in wait mode |
| cfg_stop | input | 1 | Stop-all-clocks strobe, valid with cfg_we |
| cfg_settle | input | 8 | Settle length in selected-source ticks |
| wait_req | input | 1 | Wait instruction strobe |
| irq | input | 1 | Interrupt request |
| cpu_ce | output | 1 | Core clock enable pulse |
| per_ce | output | 1 | Peripheral clock enable pulse |
| sub_ce | output | 1 | Sub-clock peripheral enable pulse |
| osc_en | output | 3 | Oscillator enables {ring, sub, main} |
| mode | output | 2 | Current power mode |

## Verification
The hardest situation to reach is the first core pulse after a stop exit. It depends on the settle count that was loaded at wake-up, on the divider having been cleared at stop entry, and on a divider code that was still pending from earlier.

The stimulus forces a known boundary with all three tick streams active. It then enters stop with a simultaneous wait strobe and checks that the stray wait strobe is ignored while stopped. After waking with an interrupt, it counts single main ticks one by one until the expected fifth-tick pulse.

Pending divider updates are exercised by writing a new code part-way through a long period. The bench then confirms that the old period completes before the new one starts.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  localparam int unsigned DIV_W     = 3;
  localparam int unsigned SRC_W     = 2;
  localparam int unsigned DIV_LOG_MAX = 4;
  localparam int unsigned CNT_W     = DIV_LOG_MAX;
  localparam logic [DIV_W-1:0] DIV_CODE_MAX = DIV_W'(DIV_LOG_MAX);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_WAIT   = 2'd1,
    MODE_STOP   = 2'd2
  } pm_mode_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_RING = 2'd2,
    SRC_ALT  = 2'd3
  } clk_src_e;

  // Terminal count of the divider: 2^code - 1 for the main source,
  // clamped at the largest ratio; undivided sources terminate at 0.
  function automatic cnt_t div_terminal(input logic [DIV_W-1:0] code,
                                        input logic [SRC_W-1:0] src);
    int unsigned e;
    e = (code > DIV_CODE_MAX) ? DIV_LOG_MAX : 32'(code);
    if (src == SRC_SUB || src == SRC_RING) return '0;
    return cnt_t'((32'd1 << e) - 32'd1);
  endfunction

endpackage

// File: rtl/clkpm_divider.sv
module clkpm_divider
  import clkpm_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 3'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic             sub_tick,
  input  logic             ring_tick,
  input  logic             osc_on,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic             hold,
  input  logic             clear,
  output logic             sel_tick,
  output logic             boundary
);

  cnt_t             cnt_q;
  logic [DIV_W-1:0] div_act_q, div_pend_q;
  logic [SRC_W-1:0] src_act_q, src_pend_q;
  logic             raw_tick;
  logic             at_term;

  always_comb begin
    case (src_act_q)
      SRC_SUB:  raw_tick = sub_tick;
      SRC_RING: raw_tick = ring_tick;
      default:  raw_tick = main_tick;
    endcase
  end

  assign sel_tick = osc_on & raw_tick;
  assign at_term  = (cnt_q == div_terminal(div_act_q, src_act_q));
  assign boundary = sel_tick & ~hold & ~clear & at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      div_act_q  <= RST_DIV;
      div_pend_q <= RST_DIV;
      src_act_q  <= SRC_MAIN;
      src_pend_q <= SRC_MAIN;
    end else begin
      if (cfg_we) begin
        div_pend_q <= cfg_div;
        src_pend_q <= cfg_src;
      end
      if (clear) begin
        cnt_q <= '0;
      end else if (sel_tick && !hold) begin
        if (at_term) begin
          cnt_q     <= '0;
          div_act_q <= div_pend_q;
          src_act_q <= src_pend_q;
        end else begin
          cnt_q <= cnt_q + cnt_t'(1);
        end
      end
    end
  end

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(div_act_q) && $stable(src_act_q))); // R9

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_terminal(div_act_q, src_act_q)); // R2

endmodule

// File: rtl/clkpm_mode_fsm.sv
module clkpm_mode_fsm
  import clkpm_pkg::*;
#(
  parameter int unsigned SETTLE_W   = 8,
  parameter int unsigned RST_SETTLE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_stop,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                wait_req,
  input  logic                irq,
  input  logic                sel_tick,
  output pm_mode_e            mode_q,
  output logic                settle_busy,
  output logic                stop_entry
);

  logic [SETTLE_W-1:0] settle_val_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                wake;

  assign stop_entry  = (mode_q == MODE_NORMAL) & cfg_we & cfg_stop;
  assign wake        = (mode_q != MODE_NORMAL) & irq;
  assign settle_busy = (settle_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_NORMAL;
      settle_val_q <= SETTLE_W'(RST_SETTLE);
      settle_q     <= '0;
    end else begin
      if (cfg_we) settle_val_q <= cfg_settle;

      case (mode_q)
        MODE_NORMAL: begin
          if (stop_entry)    mode_q <= MODE_STOP;
          else if (wait_req) mode_q <= MODE_WAIT;
        end
        MODE_WAIT: if (wake) mode_q <= MODE_NORMAL;
        MODE_STOP: if (wake) mode_q <= MODE_NORMAL;
        default:   mode_q <= MODE_NORMAL;
      endcase

      if (wake && mode_q == MODE_STOP)
        settle_q <= settle_val_q;
      else if (settle_busy && sel_tick)
        settle_q <= settle_q - SETTLE_W'(1);
    end
  end

  AST_MODE_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3); // R10

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT && !irq) |=> mode_q == MODE_WAIT); // R7

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && !irq) |=> mode_q == MODE_STOP); // R7

  AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_NORMAL && irq) |=> mode_q == MODE_NORMAL); // R7

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> mode_q == MODE_STOP); // R6

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int unsigned      SETTLE_W   = 8,
  parameter int unsigned      RST_SETTLE = 4,
  parameter logic [DIV_W-1:0] RST_DIV    = 3'd3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                main_tick,
  input  logic                sub_tick,
  input  logic                ring_tick,
  input  logic                cfg_we,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic                cfg_pgate,
  input  logic                cfg_stop,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                wait_req,
  input  logic                irq,
  output logic                cpu_ce,
  output logic                per_ce,
  output logic                sub_ce,
  output logic [2:0]          osc_en,
  output logic [1:0]          mode
);

  pm_mode_e mode_q;
  logic     osc_on;
  logic     sel_tick;
  logic     boundary;
  logic     settle_busy;
  logic     stop_entry;
  logic     pgate_q;

  assign osc_on = (mode_q != MODE_STOP);

  clkpm_divider #(.RST_DIV(RST_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_tick (main_tick),
    .sub_tick  (sub_tick),
    .ring_tick (ring_tick),
    .osc_on    (osc_on),
    .cfg_we    (cfg_we),
    .cfg_div   (cfg_div),
    .cfg_src   (cfg_src),
    .hold      (settle_busy),
    .clear     (stop_entry),
    .sel_tick  (sel_tick),
    .boundary  (boundary)
  );

  clkpm_mode_fsm #(.SETTLE_W(SETTLE_W), .RST_SETTLE(RST_SETTLE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_stop    (cfg_stop),
    .cfg_settle  (cfg_settle),
    .wait_req    (wait_req),
    .irq         (irq),
    .sel_tick    (sel_tick),
    .mode_q      (mode_q),
    .settle_busy (settle_busy),
    .stop_entry  (stop_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgate_q <= 1'b0;
    else if (cfg_we) pgate_q <= cfg_pgate;
  end

  assign cpu_ce = boundary & (mode_q == MODE_NORMAL);
  assign per_ce = boundary & ((mode_q == MODE_NORMAL) |
                              ((mode_q == MODE_WAIT) & ~pgate_q));
  assign sub_ce = sub_tick & osc_on;
  assign osc_en = {3{osc_on}};
  assign mode   = mode_q;

  AST_WAIT_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT) |-> !cpu_ce); // R4

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP) |-> (!cpu_ce && !per_ce && !sub_ce)); // R6

  AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> (!cpu_ce && !per_ce)); // R8

  AST_CPU_IMPLIES_PER: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> per_ce); // R4

endmodule

// File: tb/clkpm_ctrl_bench.sv
module clkpm_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // {div[2:0], src[1:0], period[4:0]}
  localparam bit [9:0] VEC [0:8] = '{
    {3'd0, 2'd0, 5'd1},
    {3'd1, 2'd0, 5'd2},
    {3'd2, 2'd0, 5'd4},
    {3'd3, 2'd0, 5'd8},
    {3'd4, 2'd0, 5'd16},
    {3'd6, 2'd0, 5'd16},
    {3'd2, 2'd1, 5'd1},
    {3'd4, 2'd2, 5'd1},
    {3'd1, 2'd3, 5'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_tick = 0, sub_tick = 0, ring_tick = 0;
  logic cfg_we = 0, cfg_pgate = 0, cfg_stop = 0;
  logic [2:0] cfg_div = 0;
  logic [1:0] cfg_src = 0;
  logic [7:0] cfg_settle = 0;
  logic wait_req = 0, irq = 0;
  logic cpu_ce, per_ce, sub_ce;
  logic [2:0] osc_en;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic s_cpu, s_per, s_sub;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkpm_ctrl u_clkpm_ctrl (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .ring_tick(ring_tick), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_src(cfg_src), .cfg_pgate(cfg_pgate), .cfg_stop(cfg_stop),
    .cfg_settle(cfg_settle), .wait_req(wait_req), .irq(irq),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .sub_ce(sub_ce), .osc_en(osc_en),
    .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit m, input bit s, input bit r);
    @(negedge clk);
    main_tick = m; sub_tick = s; ring_tick = r;
    #1;
    s_cpu = cpu_ce; s_per = per_ce; s_sub = sub_ce;
    @(posedge clk); #1;
    main_tick = 0; sub_tick = 0; ring_tick = 0;
  endtask

  task automatic wr_cfg(input bit [2:0] d, input bit [1:0] sr, input bit pg,
                        input bit [7:0] st, input bit stp, input bit wr);
    @(negedge clk);
    cfg_we = 1; cfg_div = d; cfg_src = sr; cfg_pgate = pg;
    cfg_settle = st; cfg_stop = stp; wait_req = wr;
    @(posedge clk); #1;
    cfg_we = 0; cfg_stop = 0; wait_req = 0;
  endtask

  task automatic ctl(input bit wr, input bit ir);
    @(negedge clk);
    wait_req = wr; irq = ir;
    @(posedge clk); #1;
    wait_req = 0; irq = 0;
  endtask

  // Run all sources together until a boundary of the old setting lands.
  task automatic apply_pending();
    bit seen;
    seen = 0;
    for (int n = 0; n < 40 && !seen; n++) begin
      step(1, 1, 1);
      seen = s_cpu;
    end
    chk("R9 boundary reached", int'(seen), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 reset mode", int'(mode), 0);
    chk("R11 reset osc_en", int'(osc_en), 7);
    chk("R1 reset cpu_ce idle", int'(cpu_ce), 0);

    // R1 default divide-by-8, R9 pending change mid-period
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0);
      chk("R1 early tick", int'(s_cpu), 0);
    end
    wr_cfg(3'd1, 2'd0, 0, 8'd3, 0, 0);
    for (int k = 3; k < 8; k++) begin
      step(1, 0, 0);
      chk("R9 old period kept", int'(s_cpu), (k == 7) ? 1 : 0);
    end
    for (int k = 0; k < 2; k++) begin
      step(1, 0, 0);
      chk("R9 new period", int'(s_cpu), (k == 1) ? 1 : 0);
    end

    // Table of divider/source settings
    foreach (VEC[i]) begin
      bit [2:0] d;
      bit [1:0] sr;
      int per;
      bit sm, ss, srg;
      d = VEC[i][9:7]; sr = VEC[i][6:5]; per = int'(VEC[i][4:0]);
      sm = (sr == 2'd0 || sr == 2'd3); ss = (sr == 2'd1); srg = (sr == 2'd2);
      wr_cfg(d, sr, 0, 8'd3, 0, 0);
      apply_pending();
      for (int k = 0; k < 2 * per; k++) begin
        step(!sm, !ss, !srg);
        chk("R3 unselected source", int'(s_cpu), 0);
        step(sm, ss, srg);
        chk("R2 R3 period", int'(s_cpu), ((k + 1) % per == 0) ? 1 : 0);
        chk("R1 per follows cpu in normal", int'(s_per), int'(s_cpu));
      end
    end

    // Wait mode
    wr_cfg(3'd1, 2'd0, 0, 8'd3, 0, 0);
    apply_pending();
    ctl(1, 0);
    chk("R4 wait entered", int'(mode), 1);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0);
      chk("R4 cpu gated in wait", int'(s_cpu), 0);
      chk("R4 per runs in wait", int'(s_per), (k % 2 == 1) ? 1 : 0);
    end
    step(0, 1, 0);
    chk("R5 sub_ce in wait", int'(s_sub), 1);
    ctl(1, 0);
    chk("R7 wait_req ignored in wait", int'(mode), 1);
    wr_cfg(3'd1, 2'd0, 1, 8'd3, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0);
      chk("R4 per gated in wait", int'(s_per), 0);
    end
    step(0, 1, 0);
    chk("R5 sub_ce despite gate", int'(s_sub), 1);
    ctl(0, 1);
    chk("R7 irq leaves wait", int'(mode), 0);
    step(1, 0, 0);
    chk("R4 normal resume first", int'(s_cpu), 0);
    step(1, 0, 0);
    chk("R4 normal resume cpu", int'(s_cpu), 1);
    chk("R4 gate no effect in normal", int'(s_per), 1);
    ctl(0, 1);
    chk("R7 irq ignored in normal", int'(mode), 0);

    // Stop mode, with simultaneous wait strobe
    wr_cfg(3'd1, 2'd0, 0, 8'd3, 1, 1);
    chk("R6 stop entered", int'(mode), 2);
    chk("R6 osc off", int'(osc_en), 0);
    step(1, 1, 1);
    chk("R6 cpu off in stop", int'(s_cpu), 0);
    chk("R6 per off in stop", int'(s_per), 0);
    chk("R5 sub off in stop", int'(s_sub), 0);
    ctl(1, 0);
    chk("R7 wait_req ignored in stop", int'(mode), 2);
    ctl(0, 1);
    chk("R7 irq leaves stop", int'(mode), 0);
    chk("R11 osc back on", int'(osc_en), 7);
    for (int k = 0; k < 5; k++) begin
      step(1, 0, 0);
      chk("R8 settle then restart", int'(s_cpu), (k == 4) ? 1 : 0);
      if (k < 3) chk("R8 per gated in settle", int'(s_per), 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule